// File: doc/BRIEF.md
# Gamma Reference Command Receiver (I2C Slave Write Front End)

This block is the serial command front end of a twelve-channel programmable reference generator. It listens on an I2C bus as a write-only slave and decodes each write transaction into one of three outcomes. The first is an ordinary register write, reported on a one-cycle strobe that carries the register address and a 16-bit word. The second is a request to return every output to code zero. The third is a request to reload the register contents from an external EEPROM. The register file and the EEPROM loader sit downstream and act on these strobes.

A transaction opens with START and an address byte. The slave address is selected by a pin. A register address byte follows, and then two data bytes with the high byte first. The receiver pulls SDA low in the ninth clock of every byte it accepts. Two special cases are recognised:
- A general call reset: address byte 0x00 followed by command byte 0x06. Its effect depends on an enable pin.
- A write to a dedicated reload register: it starts an EEPROM reload when the last bit of the word is set.

Both bus lines pass through a two-flop synchroniser. Bus edges are found by oversampling on the system clock. The receiver is a single enumerated state machine with these states:
- ST_IDLE: bus free.
- ST_ADDR: shifting in the address byte.
- ST_REG: shifting in the register address.
- ST_DHI: shifting in the high data byte.
- ST_DLO: shifting in the low data byte.
- ST_GCMD: shifting in the general call command byte.
- ST_ACK: driving the acknowledge.
- ST_IGNORE: SDA released until the next START.

Its transitions are:
- START from any state moves to ST_ADDR.
- STOP from any state moves to ST_IDLE.
- From ST_ADDR, a matching address goes to ST_ACK, which then leads to ST_REG. The general call address goes to ST_ACK, which then leads to ST_GCMD. Any other address byte goes to ST_IGNORE.
- From ST_REG to ST_ACK, then to ST_DHI.
- From ST_DHI to ST_ACK, then to ST_DLO.
- From ST_DLO to ST_ACK, then to ST_IGNORE, and the word action fires.
- From ST_GCMD, command byte 0x06 goes to ST_ACK, then to ST_IGNORE, and the reset action fires. Any other command byte goes to ST_IGNORE.
- ST_ACK moves on at the SCL falling edge that closes the ninth clock.

Top module: `gamma_i2c_cmd_slave`

## Requirements
- R1: The address byte is acknowledged (SDA held low in the ninth clock) when its upper seven bits equal 0x74 with `addr_pin` low, or 0x75 with `addr_pin` high, and its last bit (the read/write bit) is 0.
- R2: An address byte that matches neither the slave address nor 0x00, or that has its last bit set to 1, is not acknowledged. SDA then stays released for all later bytes until the next START.
- R3: After an accepted device address, the register address byte and both data bytes are each acknowledged in their ninth clock. The acknowledge drive only changes while SCL is low.
- R4: The data word is the first data byte in bits 15:8 and the second in bits 7:0. `wr_stb` pulses once, after the second data byte has been acknowledged, with `wr_reg` and `wr_data` valid. Any further byte in the same transaction is not acknowledged.
- R5: A STOP or repeated START before the second data byte has been acknowledged discards the partial transfer without any strobe. A repeated START begins a new address phase.
- R6: A write to register 0x1C raises `reload_stb`, and not `wr_stb`, exactly when bit 0 of the second data byte is 1. All other bits of both data bytes have no effect. With that bit 0, no strobe fires.
- R7: Address byte 0x00 followed by byte 0x06 is acknowledged in both bytes. It then raises `zero_all_stb` when `en_pin` is low, or `reload_stb` when `en_pin` is high.
- R8: After address byte 0x00, any second byte other than 0x06 is not acknowledged and raises no strobe.
- R9: While `rst_n` is low, `sda_oe` and all three strobes are low.
- R10: Each strobe is a single-cycle pulse, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | I2C clock line level, asynchronous |
| sda_in | input | 1 | I2C data line level, asynchronous |
| addr_pin | input | 1 | Selects bit 0 of the 7-bit slave address |
| en_pin | input | 1 | Selects the general call reset outcome: 0 zero all outputs, 1 EEPROM reload |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_reg | output | 8 | Register address of the write |
| wr_data | output | 16 | Data word of the write |
| zero_all_stb | output | 1 | One-cycle request to set all outputs to code 0 |
| reload_stb | output | 1 | One-cycle request to reload from EEPROM |

## Verification
The ordinary word-write decode and the reload decode are both resolved in the same ack-completion cycle, from the same register address and the same low data byte. Exactly one or neither of `wr_stb` and `reload_stb` must fire there. The bench provokes this with writes to 0x1C using every combination of the low byte's bit 0 and mixed don't-care bits, and with writes to the neighbouring registers 0x1B and 0x1D. It judges each transaction by counting the pulses of each strobe and comparing the counts with an expectation computed from the register address and bit 0. The general call path reaches the same cycle with `reload_stb` or `zero_all_stb`, and is judged the same way under both `en_pin` levels.

// File: rtl/gref_pkg.sv
package gref_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_DHI,
        ST_DLO,
        ST_GCMD,
        ST_ACK,
        ST_IGNORE
    } state_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_WORD,
        ACT_RELOAD,
        ACT_GC
    } act_t;
endpackage

// File: rtl/gref_line_sync.sv
module gref_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign start_det = scl_s && scl_q && sda_q && !sda_s;
    assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/gref_cmd_fsm.sv
module gref_cmd_fsm
    import gref_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR   = 7'h74,
    parameter logic [BYTE_W-1:0] RELOAD_REG = 8'h1C,
    parameter logic [BYTE_W-1:0] GC_CODE    = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_pin,
    input  logic              en_pin,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_reg,
    output logic [WORD_W-1:0] wr_data,
    output logic              zero_all_stb,
    output logic              reload_stb
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    state_t state_q, state_d;
    state_t after_q, after_d;
    act_t   act_q, act_d;

    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] reg_q;
    logic [BYTE_W-1:0] hi_q;
    logic [WORD_W-1:0] data_q;
    logic [BYTE_W-1:0] my_addr_byte;
    logic              receiving;
    logic              byte_done;
    logic              fire;

    assign my_addr_byte = {DEV_ADDR[6:1], addr_pin, 1'b0};
    assign receiving    = (state_q == ST_ADDR) || (state_q == ST_REG) ||
                          (state_q == ST_DHI)  || (state_q == ST_DLO) ||
                          (state_q == ST_GCMD);
    assign byte_done    = scl_fall && (cnt_q == CNT_FULL);
    assign fire         = (state_q == ST_ACK) && scl_fall;

    // next-state logic
    always_comb begin
        state_d = state_q;
        after_d = after_q;
        act_d   = act_q;
        if (start_det) begin
            state_d = ST_ADDR;
            act_d   = ACT_NONE;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            act_d   = ACT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        if (shift_q == my_addr_byte) begin
                            state_d = ST_ACK;
                            after_d = ST_REG;
                        end else if (shift_q == '0) begin
                            state_d = ST_ACK;
                            after_d = ST_GCMD;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_REG: begin
                    if (byte_done) begin
                        state_d = ST_ACK;
                        after_d = ST_DHI;
                    end
                end
                ST_DHI: begin
                    if (byte_done) begin
                        state_d = ST_ACK;
                        after_d = ST_DLO;
                    end
                end
                ST_DLO: begin
                    if (byte_done) begin
                        state_d = ST_ACK;
                        after_d = ST_IGNORE;
                        if (reg_q != RELOAD_REG) begin
                            act_d = ACT_WORD;
                        end else if (shift_q[0]) begin
                            act_d = ACT_RELOAD;
                        end else begin
                            act_d = ACT_NONE;
                        end
                    end
                end
                ST_GCMD: begin
                    if (byte_done) begin
                        if (shift_q == GC_CODE) begin
                            state_d = ST_ACK;
                            after_d = ST_IGNORE;
                            act_d   = ACT_GC;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_d = after_q;
                        act_d   = ACT_NONE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
            act_q   <= ACT_NONE;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            act_q   <= act_d;
        end
    end

    // bit shifter and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            reg_q   <= '0;
            hi_q    <= '0;
            data_q  <= '0;
        end else begin
            if (start_det || fire) begin
                cnt_q <= '0;
            end else if (scl_rise && receiving && cnt_q != CNT_FULL) begin
                cnt_q   <= cnt_q + 1'b1;
                shift_q <= {shift_q[BYTE_W-2:0], sda_s};
            end
            if (byte_done && state_q == ST_REG) reg_q <= shift_q;
            if (byte_done && state_q == ST_DHI) hi_q  <= shift_q;
            if (byte_done && state_q == ST_DLO) data_q <= {hi_q, shift_q};
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_oe       <= 1'b0;
            wr_stb       <= 1'b0;
            wr_reg       <= '0;
            wr_data      <= '0;
            zero_all_stb <= 1'b0;
            reload_stb   <= 1'b0;
        end else begin
            sda_oe       <= (state_d == ST_ACK);
            wr_stb       <= fire && (act_q == ACT_WORD);
            zero_all_stb <= fire && (act_q == ACT_GC) && !en_pin;
            reload_stb   <= fire && ((act_q == ACT_RELOAD) ||
                                     ((act_q == ACT_GC) && en_pin));
            if (fire && act_q == ACT_WORD) begin
                wr_reg  <= reg_q;
                wr_data <= data_q;
            end
        end
    end
endmodule

// File: rtl/gamma_i2c_cmd_slave.sv
module gamma_i2c_cmd_slave
    import gref_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h74,
    parameter logic [7:0] RELOAD_REG  = 8'h1C,
    parameter logic [7:0] GC_CODE     = 8'h06
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        addr_pin,
    input  logic        en_pin,
    output logic        sda_oe,
    output logic        wr_stb,
    output logic [7:0]  wr_reg,
    output logic [15:0] wr_data,
    output logic        zero_all_stb,
    output logic        reload_stb
);
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    gref_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    gref_cmd_fsm #(
        .DEV_ADDR  (DEV_ADDR),
        .RELOAD_REG(RELOAD_REG),
        .GC_CODE   (GC_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .addr_pin    (addr_pin),
        .en_pin      (en_pin),
        .sda_oe      (sda_oe),
        .wr_stb      (wr_stb),
        .wr_reg      (wr_reg),
        .wr_data     (wr_data),
        .zero_all_stb(zero_all_stb),
        .reload_stb  (reload_stb)
    );
endmodule

// File: rtl/gref_cmd_checker.sv
module gref_cmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       en_pin,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic [7:0] wr_reg,
    input logic       zero_all_stb,
    input logic       reload_stb
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !wr_stb && !zero_all_stb && !reload_stb)); // R9

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_stb, zero_all_stb, reload_stb}) <= 1); // R10

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R10

    AST_RELOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |=> !reload_stb); // R10

    AST_NO_WR_TO_RELOAD_REG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_reg != 8'h1C)); // R6

    AST_GC_ZERO_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        zero_all_stb |-> !$past(en_pin)); // R7

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_in); // R3
endmodule

bind gamma_i2c_cmd_slave gref_cmd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_in),
    .en_pin      (en_pin),
    .sda_oe      (sda_oe),
    .wr_stb      (wr_stb),
    .wr_reg      (wr_reg),
    .zero_all_stb(zero_all_stb),
    .reload_stb  (reload_stb)
);

// File: tb/sim_gamma_i2c_cmd_slave.sv
`timescale 1ns/1ps
module sim_gamma_i2c_cmd_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_pin = 1'b0;
    logic        en_pin = 1'b0;
    logic        sda_oe;
    logic        wr_stb;
    logic [7:0]  wr_reg;
    logic [15:0] wr_data;
    logic        zero_all_stb;
    logic        reload_stb;
    logic        sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int n_wr = 0;
    int n_zero = 0;
    int n_rel = 0;
    logic [7:0]  got_reg = '0;
    logic [15:0] got_data = '0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    gamma_i2c_cmd_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .addr_pin    (addr_pin),
        .en_pin      (en_pin),
        .sda_oe      (sda_oe),
        .wr_stb      (wr_stb),
        .wr_reg      (wr_reg),
        .wr_data     (wr_data),
        .zero_all_stb(zero_all_stb),
        .reload_stb  (reload_stb)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            n_wr     <= n_wr + 1;
            got_reg  <= wr_reg;
            got_data <= wr_data;
        end
        if (zero_all_stb) n_zero <= n_zero + 1;
        if (reload_stb)   n_rel  <= n_rel + 1;
    end

    task automatic check(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q/2);
        ack = ~sda_line;
        wq(Q/2);
        scl_m = 1'b0; wq(Q);
    endtask

    // full word write: returns the four ack bits, address first in bit 3
    task automatic write_word(input logic [7:0] ab, input logic [7:0] rg,
                              input logic [7:0] hi, input logic [7:0] lo,
                              output logic [3:0] acks);
        logic a;
        bus_start();
        send_byte(ab, a); acks[3] = a;
        send_byte(rg, a); acks[2] = a;
        send_byte(hi, a); acks[1] = a;
        send_byte(lo, a); acks[0] = a;
        bus_stop();
    endtask

    initial begin
        int wr0, z0, r0;
        logic a;
        logic [3:0] acks;
        logic [15:0] w;

        // R9: reset state
        wq(3);
        check("R9 sda_oe in reset", int'(sda_oe), 0);
        check("R9 strobes in reset", int'({wr_stb, zero_all_stb, reload_stb}), 0);
        wq(5);
        rst_n = 1'b1;
        wq(10);

        // R1 R2: sweep every 7-bit address with both addr_pin levels
        wr0 = n_wr; z0 = n_zero; r0 = n_rel;
        for (int p = 0; p < 2; p++) begin
            addr_pin = p[0];
            for (int ad = 0; ad < 128; ad++) begin
                bus_start();
                send_byte({ad[6:0], 1'b0}, a);
                bus_stop();
                check(((ad == 0) || (ad == (8'h74 | p))) ? "R1 address ack" : "R2 address nack",
                      int'(a), int'((ad == 0) || (ad == (8'h74 | p))));
            end
        end
        check("R2 no strobe during sweep", (n_wr - wr0) + (n_zero - z0) + (n_rel - r0), 0);

        // R2: read bit set is not acknowledged
        addr_pin = 1'b0;
        bus_start();
        send_byte(8'hE9, a);
        check("R2 read bit nack", int'(a), 0);
        send_byte(8'h00, a);
        check("R2 released after nack", int'(a), 0);
        bus_stop();

        // R2: wrong address then further bytes stay unacknowledged
        bus_start();
        send_byte(8'hEA, a);
        check("R2 other address nack", int'(a), 0);
        send_byte(8'hE8, a);
        check("R2 matching byte after nack ignored", int'(a), 0);
        bus_stop();

        // R3 R4: word writes to all twelve channels of both banks
        for (int k = 0; k < 24; k++) begin
            w = 16'((k * 16'h0B3D) ^ 16'hA55A);
            wr0 = n_wr; r0 = n_rel;
            write_word(8'hE8, 8'(k), w[15:8], w[7:0], acks);
            check("R3 all four bytes acked", int'(acks), 4'hF);
            check("R4 one write strobe", n_wr - wr0, 1);
            check("R4 register address", int'(got_reg), k);
            check("R4 word msb first", int'(got_data), int'(w));
            check("R6 no reload on plain write", n_rel - r0, 0);
        end

        // R4: extra byte after the word is not acknowledged
        wr0 = n_wr;
        bus_start();
        send_byte(8'hE8, a);
        send_byte(8'h07, a);
        send_byte(8'h12, a);
        send_byte(8'h34, a);
        send_byte(8'h56, a);
        check("R4 extra byte nack", int'(a), 0);
        bus_stop();
        check("R4 single strobe with extra byte", n_wr - wr0, 1);
        check("R4 extra byte not merged", int'(got_data), 16'h1234);

        // R1: addr_pin high selects 0x75
        addr_pin = 1'b1;
        wr0 = n_wr;
        write_word(8'hEA, 8'h0B, 8'hC3, 8'h3C, acks);
        check("R1 pin-high address acked", int'(acks), 4'hF);
        check("R1 pin-high write data", int'(got_data), 16'hC33C);
        write_word(8'hE8, 8'h0B, 8'h11, 8'h22, acks);
        check("R1 0x74 rejected when pin high", int'(acks[3]), 0);
        check("R1 no write on wrong address", n_wr - wr0, 1);
        addr_pin = 1'b0;

        // R5: STOP after high byte discards
        wr0 = n_wr;
        bus_start();
        send_byte(8'hE8, a);
        send_byte(8'h02, a);
        send_byte(8'h99, a);
        bus_stop();
        check("R5 stop discards partial word", n_wr - wr0, 0);

        // R5: STOP after register byte discards
        bus_start();
        send_byte(8'hE8, a);
        send_byte(8'h1C, a);
        bus_stop();
        check("R5 stop after reg byte", (n_wr - wr0) + (n_rel - r0), 0);

        // R5: repeated START after high byte, then a full new write
        wr0 = n_wr;
        bus_start();
        send_byte(8'hE8, a);
        send_byte(8'h03, a);
        send_byte(8'h12, a);
        bus_start();
        send_byte(8'hE8, a);
        check("R5 address after repeated start acked", int'(a), 1);
        send_byte(8'h04, a);
        send_byte(8'hBE, a);
        send_byte(8'hEF, a);
        bus_stop();
        check("R5 only the new word written", n_wr - wr0, 1);
        check("R5 new register", int'(got_reg), 8'h04);
        check("R5 new data", int'(got_data), 16'hBEEF);

        // R6: reload register and its neighbours, varying don't-care bits
        for (int r = 8'h1B; r <= 8'h1D; r++) begin
            for (int v = 0; v < 4; v++) begin
                logic [7:0] hi_b;
                logic [7:0] lo_b;
                hi_b = 8'(v * 8'h5B);
                lo_b = {v[1] ? 7'h7F : 7'h2A, v[0]};
                wr0 = n_wr; r0 = n_rel; z0 = n_zero;
                write_word(8'hE8, 8'(r), hi_b, lo_b, acks);
                check("R6 reload reg bytes acked", int'(acks), 4'hF);
                check("R6 reload strobe count", n_rel - r0, int'((r == 8'h1C) && v[0]));
                check("R6 write strobe count", n_wr - wr0, int'(r != 8'h1C));
                check("R6 no zero strobe", n_zero - z0, 0);
            end
        end

        // R7: general call reset, both enable levels
        for (int e = 0; e < 2; e++) begin
            en_pin = e[0];
            wr0 = n_wr; r0 = n_rel; z0 = n_zero;
            bus_start();
            send_byte(8'h00, a);
            check("R7 general call address acked", int'(a), 1);
            send_byte(8'h06, a);
            check("R7 reset code acked", int'(a), 1);
            bus_stop();
            check("R7 zero-all strobe", n_zero - z0, 1 - e);
            check("R7 reload strobe", n_rel - r0, e);
            check("R7 no write strobe", n_wr - wr0, 0);
        end
        en_pin = 1'b0;

        // R8: other general call codes
        for (int c = 0; c < 16; c++) begin
            logic [7:0] code;
            code = 8'(c * 8'h11 + 8'h01);
            if (code != 8'h06) begin
                r0 = n_rel; z0 = n_zero;
                bus_start();
                send_byte(8'h00, a);
                send_byte(code, a);
                bus_stop();
                check("R8 other code nack", int'(a), 0);
                check("R8 other code no strobe", (n_rel - r0) + (n_zero - z0), 0);
            end
        end

        // R10: strobes idle between transactions
        wq(4);
        check("R10 strobes low when idle", int'({wr_stb, zero_all_stb, reload_stb}), 0);
        check("R3 sda released when idle", int'(sda_oe), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule